// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This unit moves 8-bit frames over a three-wire synchronous link on which it is the clock master. A bus-side write fills a one-entry transmit holding register. When transmission is active, the frame moves into a shift register and goes out on the serial data output, one bit per generated clock period. The serial clock is produced only while a frame is shifting. The serial data input is sampled on the same clock, so every transmitted frame can also carry one received frame into a receive holding register. Reception therefore depends on the transmitter running.

A 4-bit divide field sets the length of one serial clock phase. Each bit spends one phase with the clock low, when the new data bit is driven, and then one phase with the clock high, when the input bit is sampled. Software chooses the bit order, the output polarity, the input polarity, and the point in the frame at which the transmit interrupt fires. A receive overrun flag reports a frame that arrived while the previous one was still unread.

The sequencer has three states. IDLE holds the clock high. LOW is the clock-low phase of a bit, and HIGH is the clock-high phase. The transitions are:
- *launch* (IDLE→LOW): on a phase tick, when transmit is active and the holding register is full.
- *sample* (LOW→HIGH): on every phase tick.
- *advance* (HIGH→LOW): on a tick before the last bit.
- *chain* (HIGH→LOW): after the last bit, when the holding register is full again.
- *stop* (HIGH→IDLE): after the last bit, when the holding register is empty.

Top module: `sss_top`

## Requirements
- R1: A frame is 8 bits. With `lsb_first`=1, bit 0 of the written byte goes out first and the first received bit lands in bit 0 of `rx_data`. With `lsb_first`=0, bit 7 goes out first and the first received bit lands in bit 7.
- R2: One clock phase lasts P base clock cycles, where P=1 when `div_sel`=0 and P=2·`div_sel` otherwise. One bit lasts 2·P cycles, so two successive rising edges of `sclk` inside a frame are 2·P cycles apart.
- R3: A frame starts only when transmit is active and the transmit holding register is full. With `tx_en`=0, a written byte stays in the register (`tx_buf_empty`=0) and `sclk` stays high. `tx_buf_empty` returns to 1 when the byte moves into the shift register.
- R4: When `rx_en`=0, frames still transmit, but `rx_irq` does not pulse and `rx_data` keeps its value.
- R5: `tx_irq` is a one-cycle pulse. With `txirq_on_done`=0 it fires when the byte moves from the holding register into the shift register, before the first `sclk` rise of that frame. With `txirq_on_done`=1 it fires at the end of the eighth bit, after the eighth `sclk` rise.
- R6: When a complete frame is copied into `rx_data`, `rx_irq` pulses for one cycle, and `rx_data` holds the new value during that cycle.
- R7: `overrun` sets when the eighth bit of a frame is sampled while the previous received byte is still unread (no `rx_rd` pulse since it arrived). It stays set until `rx_en` is driven low. A read before that point prevents the flag.
- R8: Between frames `sclk` is high and `sdo` equals 1 XOR `out_inv`. While a frame shifts, `sdo` carries each data bit XOR `out_inv`.
- R9: With `in_inv`=1, the level on `sdi` is inverted before it is shifted in. In loopback (`sdi` tied to `sdo`), `rx_data` then equals the sent byte XOR 8'hFF when exactly one of `out_inv` and `in_inv` is set, and equals the sent byte otherwise.
- R10: `tx_en` and `rx_en` are taken on phase ticks and act from the following tick. After `tx_en` rises with data waiting, `sclk` stays high for at least P base cycles.
- R11: If a new byte is written while a frame shifts, the next frame follows with no idle phase, so rising edges stay 2·P apart across the frame boundary. Otherwise `sclk` stays high after the eighth bit.
- R12: `sdo` changes only as `sclk` falls, or as the link returns to idle. The receiver samples `sdi` at the phase in which `sclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| out_inv | input | 1 | Inverts serial output and its idle level |
| in_inv | input | 1 | Inverts serial input |
| txirq_on_done | input | 1 | 0: transmit interrupt on buffer load, 1: on frame end |
| div_sel | input | 4 | Phase length select (0 = no division) |
| tx_wr | input | 1 | Write strobe for transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe, marks the received byte as taken |
| rx_data | output | 8 | Received byte |
| tx_buf_empty | output | 1 | Transmit holding register is empty |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_irq | output | 1 | Receive interrupt request pulse |
| overrun | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | Generated serial clock, idles high |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
The hardest situation to reach is the *chain* transition. It needs a second write to land in the short window after the first byte leaves the holding register and before the eighth bit ends. The driver gets there by waiting on `tx_buf_empty` and writing straight away, at the fastest divide setting. The spacing of every `sclk` rise across the frame boundary then shows whether an idle phase crept in. Overrun is reached by turning off the automatic read in the monitor and sending two frames, and the flag is checked between them.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int FRAME_W = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOW,
        S_HIGH
    } sss_state_e;

    // bit that is presented on the line first from the current shift contents
    function automatic logic head_bit(input logic [FRAME_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[FRAME_W-1];
    endfunction

    // discard the bit just sent
    function automatic logic [FRAME_W-1:0] drop_head(input logic [FRAME_W-1:0] v, input logic lsb);
        return lsb ? {1'b0, v[FRAME_W-1:1]} : {v[FRAME_W-2:0], 1'b0};
    endfunction

    // insert a received bit so that the first one ends at bit 0 (lsb) or bit 7
    function automatic logic [FRAME_W-1:0] push_bit(input logic [FRAME_W-1:0] v, input logic b,
                                                    input logic lsb);
        return lsb ? {b, v[FRAME_W-1:1]} : {v[FRAME_W-2:0], b};
    endfunction

endpackage

// File: rtl/sss_clkdiv.sv
module sss_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = (div_sel == '0) ? CNT_W'(1) : {div_sel, 1'b0};
    assign tick  = (cnt_q >= limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0 && $stable(div_sel)) |=> (!tick || !$stable(div_sel)));

endmodule

// File: rtl/sss_txbuf.sv
module sss_txbuf #(
    parameter int W = sss_pkg::FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] data,
    output logic         empty
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            data  <= wdata;
            empty <= 1'b0;
        end else if (load) begin
            empty <= 1'b1;
        end
    end

    // R3
    load_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !empty);

endmodule

// File: rtl/sss_fsm.sv
module sss_fsm
    import sss_pkg::*;
#(
    parameter int W     = FRAME_W,
    parameter int IDX_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         tx_en,
    input  logic         rx_en,
    input  logic         lsb_first,
    input  logic         txirq_on_done,
    input  logic         tx_full,
    input  logic [W-1:0] tx_data,
    output logic         load,
    output logic         tx_irq,
    output logic         sclk,
    output logic         sdo_raw,
    output logic         rx_act,
    output logic         sample_stb,
    output logic         sample_last,
    output logic         frame_done
);
    sss_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     tsh_q, tsh_nxt;
    logic             sclk_q, sdo_q, tx_act_q, rx_act_q;
    logic             last, start;

    assign last    = (idx_q == IDX_W'(W - 1));
    assign tsh_nxt = drop_head(tsh_q, lsb_first);

    // next state and launch decision
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            S_IDLE: if (tick && tx_act_q && tx_full) begin
                state_d = S_LOW;
                start   = 1'b1;
            end
            S_LOW:  if (tick) state_d = S_HIGH;
            S_HIGH: if (tick) begin
                if (!last) begin
                    state_d = S_LOW;
                end else if (tx_act_q && tx_full) begin
                    state_d = S_LOW;
                    start   = 1'b1;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // strobes toward the buffers
    always_comb begin
        load        = start;
        sample_stb  = (state_q == S_LOW) && tick;
        sample_last = sample_stb && last;
        frame_done  = (state_q == S_HIGH) && tick && last;
        tx_irq      = txirq_on_done ? frame_done : start;
        sclk        = sclk_q;
        sdo_raw     = sdo_q;
        rx_act      = rx_act_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and line registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            tsh_q    <= '0;
            sclk_q   <= 1'b1;
            sdo_q    <= 1'b1;
            tx_act_q <= 1'b0;
            rx_act_q <= 1'b0;
        end else begin
            if (tick) begin
                tx_act_q <= tx_en;
                rx_act_q <= rx_en;
            end
            if (start) begin
                tsh_q  <= tx_data;
                sdo_q  <= head_bit(tx_data, lsb_first);
                idx_q  <= '0;
                sclk_q <= 1'b0;
            end else if (sample_stb) begin
                sclk_q <= 1'b1;
            end else if (state_q == S_HIGH && tick) begin
                if (!last) begin
                    tsh_q  <= tsh_nxt;
                    sdo_q  <= head_bit(tsh_nxt, lsb_first);
                    idx_q  <= idx_q + IDX_W'(1);
                    sclk_q <= 1'b0;
                end else begin
                    sdo_q  <= 1'b1;
                    sclk_q <= 1'b1;
                end
            end
        end
    end

    // R8
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> sclk_q);

    // R12
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> (!sclk_q || state_q == S_IDLE));

    // R5
    tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

endmodule

// File: rtl/sss_rxbuf.sv
module sss_rxbuf
    import sss_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         rx_act,
    input  logic         sample_stb,
    input  logic         sample_last,
    input  logic         frame_done,
    input  logic         bit_in,
    input  logic         lsb_first,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         irq,
    output logic         overrun
);
    logic [W-1:0] rsh_q, data_q;
    logic         full_q, irq_q, ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsh_q  <= '0;
            data_q <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            irq_q <= frame_done && rx_act;
            if (sample_stb && rx_act) rsh_q <= push_bit(rsh_q, bit_in, lsb_first);
            if (frame_done && rx_act) begin
                data_q <= rsh_q;
                full_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
            end
            if (!rx_en)                              ovr_q <= 1'b0;
            else if (sample_last && rx_act && full_q) ovr_q <= 1'b1;
        end
    end

    assign data    = data_q;
    assign irq     = irq_q;
    assign overrun = ovr_q;

    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(full_q));

    // R6
    rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R4
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_act |=> $stable(data_q));

endmodule

// File: rtl/sss_top.sv
module sss_top
    import sss_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int W     = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             lsb_first,
    input  logic             out_inv,
    input  logic             in_inv,
    input  logic             txirq_on_done,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             tx_wr,
    input  logic [W-1:0]     tx_wdata,
    input  logic             rx_rd,
    output logic [W-1:0]     rx_data,
    output logic             tx_buf_empty,
    output logic             tx_irq,
    output logic             rx_irq,
    output logic             overrun,
    output logic             sclk,
    output logic             sdo,
    input  logic             sdi
);
    logic         tick, load, sdo_raw, rx_act;
    logic         sample_stb, sample_last, frame_done;
    logic [W-1:0] tx_data;

    sss_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
    );

    sss_txbuf #(.W(W)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata),
        .load(load), .data(tx_data), .empty(tx_buf_empty)
    );

    sss_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .rx_en(rx_en),
        .lsb_first(lsb_first), .txirq_on_done(txirq_on_done),
        .tx_full(!tx_buf_empty), .tx_data(tx_data), .load(load), .tx_irq(tx_irq),
        .sclk(sclk), .sdo_raw(sdo_raw), .rx_act(rx_act), .sample_stb(sample_stb),
        .sample_last(sample_last), .frame_done(frame_done)
    );

    sss_rxbuf #(.W(W)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_act(rx_act),
        .sample_stb(sample_stb), .sample_last(sample_last), .frame_done(frame_done),
        .bit_in(sdi ^ in_inv), .lsb_first(lsb_first), .rd(rx_rd),
        .data(rx_data), .irq(rx_irq), .overrun(overrun)
    );

    assign sdo = sdo_raw ^ out_inv;

endmodule

// File: tb/sss_top_tb.sv
`timescale 1ns/100ps
module sss_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 0, rx_en = 0, lsb_first = 1, out_inv = 0, in_inv = 0, txirq_on_done = 0;
    logic [3:0] div_sel = 0;
    logic       tx_wr = 0;
    logic [7:0] tx_wdata = 0;
    logic       rx_rd = 0;
    logic [7:0] rx_data;
    logic       tx_buf_empty, tx_irq, rx_irq, overrun, sclk, sdo, sdi;

    always #2.5 clk = ~clk;
    assign sdi = sdo;   // loopback

    sss_top u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .lsb_first(lsb_first),
        .out_inv(out_inv), .in_inv(in_inv), .txirq_on_done(txirq_on_done), .div_sel(div_sel),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_buf_empty(tx_buf_empty), .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun),
        .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    // monitor state
    int  cyc = 0, rise_cnt = 0, last_rise = -1, rise_prd = 0, max_prd = 0;
    int  irq_cnt = 0, irq_snap = 0, rx_irq_cnt = 0, nbits = 0;
    bit  auto_read = 1, prev_sclk = 1;
    logic [7:0] shifted = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue the expected items, then write the byte
    task automatic send(input logic [7:0] b, input bit exp_rx);
        while (!tx_buf_empty) @(negedge clk);
        tx_q.push_back(b);
        if (exp_rx) rx_q.push_back(b ^ ((in_inv ^ out_inv) ? 8'hFF : 8'h00));
        tx_wdata = b;
        tx_wr    = 1'b1;
        @(negedge clk);
        tx_wr    = 1'b0;
    endtask

    task automatic reset_prd();
        last_rise = -1;
        max_prd   = 0;
    endtask

    // monitor: decodes frames at sclk rises and compares against the queues
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rx_rd = 1'b0;
            if (rst_n && sclk && !prev_sclk) begin
                rise_cnt++;
                if (last_rise >= 0) begin
                    rise_prd = cyc - last_rise;
                    if (rise_prd > max_prd) max_prd = rise_prd;
                end
                last_rise = cyc;
                if (lsb_first) shifted[nbits] = sdo ^ out_inv;
                else           shifted[7 - nbits] = sdo ^ out_inv;
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (tx_q.size() == 0) chk(0, "R1 R8 R12 unexpected frame", shifted, 0);
                    else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        chk(shifted == e, "R1 R8 R12 transmitted frame", shifted, e);
                    end
                end
            end
            if (tx_irq) begin
                irq_cnt++;
                irq_snap = rise_cnt;
            end
            if (rx_irq) begin
                rx_irq_cnt++;
                if (auto_read) begin
                    if (rx_q.size() == 0) chk(0, "R6 unexpected receive", rx_data, 0);
                    else begin
                        logic [7:0] e;
                        e = rx_q.pop_front();
                        chk(rx_data == e, "R6 R9 received byte", rx_data, e);
                    end
                    rx_rd = 1'b1;
                end
            end
            prev_sclk = sclk;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int r0, ic, rc;
        logic [7:0] held;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // reset state
        chk(sclk == 1 && sdo == 1, "R8 idle levels after reset", {sclk, sdo}, 2'b11);
        chk(tx_buf_empty == 1 && !tx_irq && !rx_irq && !overrun, "R3 reset flags",
            {tx_buf_empty, tx_irq, rx_irq, overrun}, 4'b1000);

        // R3 and R10: data waits while transmit is disabled, then starts late enough
        div_sel = 2; rx_en = 1;
        cycles(10);
        send(8'h5A, 1);
        cycles(40);
        chk(rise_cnt == 0 && sclk == 1 && tx_buf_empty == 0, "R3 held while tx disabled",
            {rise_cnt[3:0], sclk, tx_buf_empty}, 6'b000010);
        tx_en = 1;
        begin
            bit stayed;
            stayed = 1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!sclk) stayed = 0;
            end
            chk(stayed, "R10 clock held high for one phase after enable", stayed, 1);
        end
        cycles(200);

        // R1 R2: LSB first, no division
        div_sel = 0; lsb_first = 1;
        cycles(4);
        reset_prd();
        send(8'hA5, 1); cycles(30);
        chk(rise_prd == 2, "R2 bit period with no division", rise_prd, 2);
        send(8'h3C, 1); cycles(30);
        send(8'h00, 1); cycles(30);
        send(8'hFF, 1); cycles(30);

        // R1 R2: MSB first, divide by 6
        div_sel = 3; lsb_first = 0;
        cycles(20);
        send(8'h81, 1); cycles(220);
        chk(rise_prd == 12, "R2 bit period at div_sel=3", rise_prd, 12);
        send(8'h6E, 1); cycles(220);
        chk(sclk == 1, "R11 clock stays high after a single frame", sclk, 1);

        // R5: transmit interrupt source
        div_sel = 0; lsb_first = 1; txirq_on_done = 0;
        cycles(4);
        r0 = rise_cnt; ic = irq_cnt;
        send(8'h12, 1); cycles(30);
        chk(irq_cnt == ic + 1 && irq_snap == r0, "R5 irq at buffer load", irq_snap - r0, 0);
        txirq_on_done = 1;
        r0 = rise_cnt; ic = irq_cnt;
        send(8'h34, 1); cycles(30);
        chk(irq_cnt == ic + 1 && irq_snap == r0 + 8, "R5 irq at frame end", irq_snap - r0, 8);
        txirq_on_done = 0;

        // R11: back-to-back frames without a gap
        reset_prd();
        r0 = rise_cnt;
        send(8'hC3, 1);
        send(8'h5E, 1);
        cycles(40);
        chk(rise_cnt == r0 + 16 && max_prd == 2, "R11 chained frames keep spacing", max_prd, 2);

        // R8 R9: polarity combinations
        out_inv = 1; in_inv = 1;
        cycles(4);
        chk(sdo == 0 && sclk == 1, "R8 inverted idle level", sdo, 0);
        send(8'hB4, 1); cycles(30);
        out_inv = 0; in_inv = 1;
        cycles(4);
        chk(sdo == 1, "R8 normal idle level", sdo, 1);
        send(8'h96, 1); cycles(30);
        out_inv = 1; in_inv = 0;
        cycles(4);
        send(8'h2D, 1); cycles(30);
        out_inv = 0; in_inv = 0;
        cycles(4);

        // R4: receive disabled
        rx_en = 0;
        cycles(4);
        rc = rx_irq_cnt; held = rx_data;
        send(8'h77, 0); cycles(30);
        chk(rx_irq_cnt == rc, "R4 no rx_irq while disabled", rx_irq_cnt - rc, 0);
        chk(rx_data == held, "R4 rx_data unchanged while disabled", rx_data, held);
        rx_en = 1;
        cycles(4);

        // R7: overrun
        chk(overrun == 0, "R7 no overrun when every byte was read", overrun, 0);
        auto_read = 0;
        send(8'h11, 0); cycles(30);
        chk(overrun == 0 && rx_data == 8'h11, "R7 first unread byte", {overrun, rx_data}, 9'h011);
        send(8'h22, 0); cycles(30);
        chk(overrun == 1, "R7 overrun on second unread frame", overrun, 1);
        rx_en = 0;
        @(negedge clk);
        chk(overrun == 0, "R7 cleared by receive disable", overrun, 0);
        rx_rd = 1;
        @(negedge clk);
        rx_en = 1;
        auto_read = 1;
        cycles(4);
        send(8'h44, 1); cycles(30);
        chk(overrun == 0, "R7 no overrun after read", overrun, 0);

        chk(tx_q.size() == 0 && rx_q.size() == 0, "R1 R6 all expected items seen",
            tx_q.size() + rx_q.size(), 0);
        finished = 1;
        finish_run();
    end
endmodule